// File: doc/BRIEF.md
# Flux Pulse Clock/Data Window Separator

This block takes the raw pulse stream from a disc drive read head, one pulse per flux transition, and splits it into two serial bit streams. Each bit cell starts when the recovered bit clock marks a cell boundary. The cell is cut into a clock window followed by a data window. A pulse anywhere in a window makes that window's bit a 1. An empty window gives a 0. When each window closes, the block presents the bit with a one-cycle strobe.

All timing runs on a fast sampling clock. A window spans a fixed number of sampling ticks. The same logic notes where inside its window each pulse lands. A pulse on the outermost ticks of a window means the recorded bit has drifted toward a window edge. Such a pulse sets a sticky margin flag. The bit value is still delivered normally. Firmware clears the flag when a read starts and reads it back once the read is over.

Top module: `sep_window_separator`

## Requirements
- R1: While reset is held and on the first cycle after it, every output is 0.
- R2: A cycle with `cell_start` high is tick 0 of a new cell. The clock window covers ticks 0 to WIN_TICKS-1 (default 0..7) and the data window covers ticks WIN_TICKS to 2*WIN_TICKS-1 (default 8..15). A cell runs 2*WIN_TICKS ticks unless a new `cell_start` cuts it short.
- R3: The clock window closes at tick WIN_TICKS-1. In the cycle after that tick, `clk_bit_vld` is high for exactly one cycle and `clk_bit` is 1 if at least one pulse arrived in the clock window, else 0. `clk_bit` is 0 whenever `clk_bit_vld` is low.
- R4: The data window closes at tick 2*WIN_TICKS-1. In the cycle after that tick, `data_bit_vld` is high for exactly one cycle and `data_bit` is 1 if at least one pulse arrived in the data window, else 0. `data_bit` is 0 whenever `data_bit_vld` is low.
- R5: Several pulses in one window still give a single bit of value 1 with a single strobe.
- R6: Pulses that arrive when no cell is running (before the first `cell_start`, or after tick 2*WIN_TICKS-1 with no new `cell_start`) produce no strobe and do not set the margin flag.
- R7: A `cell_start` that arrives while a window is still open closes that window. Its strobe and accumulated bit appear in the next cycle. A pulse in that same cycle belongs to the new cell's clock window.
- R8: A pulse on one of the first EDGE_TICKS or last EDGE_TICKS ticks of either window (default ticks 0, 7, 8 and 15) sets `margin_flag` in the next cycle. The bit value for that window is unchanged.
- R9: A pulse on any other tick of a window leaves `margin_flag` unchanged.
- R10: `margin_flag` stays set until `margin_clr` is high, and then it reads 0 from the next cycle. If a marginal pulse arrives in the same cycle as `margin_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_start | input | 1 | Bit-cell boundary strobe from the recovered bit clock |
| flux_pulse | input | 1 | One-cycle pulse per flux transition from the drive |
| margin_clr | input | 1 | Clears the sticky margin flag |
| clk_bit | output | 1 | Separated clock bit, valid with `clk_bit_vld` |
| clk_bit_vld | output | 1 | One-cycle strobe when a clock window closes |
| data_bit | output | 1 | Separated data bit, valid with `data_bit_vld` |
| data_bit_vld | output | 1 | One-cycle strobe when a data window closes |
| margin_flag | output | 1 | Sticky flag for a pulse near a window edge |

## Verification
A tick counter that is off by one moves a strobe to the wrong cycle, or lands a pulse in the neighbouring window. Either fault shows at the ports within one cell of 2*WIN_TICKS cycles, so the bench checks the cycle of every strobe as well as its bit. A window-open flag stuck high or low shows up as a missing or doubled strobe, or as a bit that leaks into the next cell; short cells and back-to-back cells expose this. Because the margin state is registered straight to its port, a wrong edge comparison or clear priority is visible one cycle after the pulse.

// File: rtl/sep_pkg.sv
package sep_pkg;

    // One separated bit: strobe plus value
    typedef struct packed {
        logic vld;
        logic val;
    } sep_bit_t;

endpackage

// File: rtl/sep_cell_timer.sv
module sep_cell_timer #(
    parameter int WIN_TICKS = 8,
    parameter int POS_W     = $clog2(2 * WIN_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_start,
    output logic             in_cell,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST_TICK = POS_W'(2 * WIN_TICKS - 1);

    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        in_cell = 1'b0;
        pos     = s_q.cnt;
        if (cell_start) begin
            in_cell = 1'b1;
            pos     = '0;
        end else if (s_q.active && (s_q.cnt != LAST_TICK)) begin
            in_cell = 1'b1;
            pos     = s_q.cnt + 1'b1;
        end
        s_d.active = in_cell;
        if (in_cell) begin
            s_d.cnt = pos;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sep_window_acc.sv
module sep_window_acc
    import sep_pkg::*;
#(
    parameter int WIN_TICKS = 8,
    parameter int POS_W     = $clog2(2 * WIN_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_start,
    input  logic             in_cell,
    input  logic [POS_W-1:0] pos,
    input  logic             flux_pulse,
    output sep_bit_t         clk_ev,
    output sep_bit_t         dat_ev
);

    localparam logic [POS_W-1:0] CLK_LAST  = POS_W'(WIN_TICKS - 1);
    localparam logic [POS_W-1:0] DAT_FIRST = POS_W'(WIN_TICKS);
    localparam logic [POS_W-1:0] DAT_LAST  = POS_W'(2 * WIN_TICKS - 1);

    typedef struct packed {
        logic     clk_open;
        logic     clk_hit;
        logic     dat_open;
        logic     dat_hit;
        sep_bit_t clk_ev;
        sep_bit_t dat_ev;
    } acc_state_t;

    acc_state_t s_q, s_d;
    logic       hit_clk;
    logic       hit_dat;

    always_comb begin
        hit_clk = flux_pulse && in_cell && (pos < DAT_FIRST);
        hit_dat = flux_pulse && in_cell && !(pos < DAT_FIRST);

        s_d        = s_q;
        s_d.clk_ev = '0;
        s_d.dat_ev = '0;

        if (cell_start) begin
            // a new boundary closes whatever is still open
            if (s_q.clk_open) begin
                s_d.clk_ev = sep_bit_t'{vld: 1'b1, val: s_q.clk_hit};
            end
            if (s_q.dat_open) begin
                s_d.dat_ev = sep_bit_t'{vld: 1'b1, val: s_q.dat_hit};
            end
            s_d.clk_open = 1'b1;
            s_d.clk_hit  = hit_clk;
            s_d.dat_open = 1'b0;
            s_d.dat_hit  = 1'b0;
        end else if (in_cell) begin
            if (s_q.clk_open) begin
                if (pos == CLK_LAST) begin
                    s_d.clk_ev   = sep_bit_t'{vld: 1'b1, val: s_q.clk_hit | hit_clk};
                    s_d.clk_open = 1'b0;
                    s_d.clk_hit  = 1'b0;
                end else begin
                    s_d.clk_hit = s_q.clk_hit | hit_clk;
                end
            end
            if (pos == DAT_FIRST) begin
                s_d.dat_open = 1'b1;
                s_d.dat_hit  = hit_dat;
            end else if (s_q.dat_open) begin
                if (pos == DAT_LAST) begin
                    s_d.dat_ev   = sep_bit_t'{vld: 1'b1, val: s_q.dat_hit | hit_dat};
                    s_d.dat_open = 1'b0;
                    s_d.dat_hit  = 1'b0;
                end else begin
                    s_d.dat_hit = s_q.dat_hit | hit_dat;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_ev = s_q.clk_ev;
    assign dat_ev = s_q.dat_ev;

endmodule

// File: rtl/sep_margin_det.sv
module sep_margin_det #(
    parameter int WIN_TICKS  = 8,
    parameter int EDGE_TICKS = 1,
    parameter int POS_W      = $clog2(2 * WIN_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_cell,
    input  logic [POS_W-1:0] pos,
    input  logic             flux_pulse,
    input  logic             margin_clr,
    output logic             margin_flag
);

    localparam logic [POS_W-1:0] WIN_SIZE = POS_W'(WIN_TICKS);
    localparam logic [POS_W-1:0] LOW_LIM  = POS_W'(EDGE_TICKS);
    localparam logic [POS_W-1:0] HIGH_LIM = POS_W'(WIN_TICKS - 1 - EDGE_TICKS);

    typedef struct packed {
        logic flag;
    } mrg_state_t;

    mrg_state_t       s_q, s_d;
    logic [POS_W-1:0] offset;
    logic             near_edge;
    logic             marginal;

    always_comb begin
        offset    = (pos < WIN_SIZE) ? pos : (pos - WIN_SIZE);
        near_edge = (offset < LOW_LIM) || (offset > HIGH_LIM);
        marginal  = in_cell && flux_pulse && near_edge;
        s_d       = s_q;
        // a fresh marginal pulse wins over a clear
        s_d.flag  = marginal | (s_q.flag & ~margin_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign margin_flag = s_q.flag;

endmodule

// File: rtl/sep_window_separator.sv
module sep_window_separator
    import sep_pkg::*;
#(
    parameter int WIN_TICKS  = 8,
    parameter int EDGE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_start,
    input  logic flux_pulse,
    input  logic margin_clr,
    output logic clk_bit,
    output logic clk_bit_vld,
    output logic data_bit,
    output logic data_bit_vld,
    output logic margin_flag
);

    localparam int POS_W = $clog2(2 * WIN_TICKS);

    logic             in_cell;
    logic [POS_W-1:0] pos;
    sep_bit_t         clk_ev;
    sep_bit_t         dat_ev;

    sep_cell_timer #(
        .WIN_TICKS (WIN_TICKS),
        .POS_W     (POS_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .in_cell    (in_cell),
        .pos        (pos)
    );

    sep_window_acc #(
        .WIN_TICKS (WIN_TICKS),
        .POS_W     (POS_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .in_cell    (in_cell),
        .pos        (pos),
        .flux_pulse (flux_pulse),
        .clk_ev     (clk_ev),
        .dat_ev     (dat_ev)
    );

    sep_margin_det #(
        .WIN_TICKS  (WIN_TICKS),
        .EDGE_TICKS (EDGE_TICKS),
        .POS_W      (POS_W)
    ) u_margin (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_cell     (in_cell),
        .pos         (pos),
        .flux_pulse  (flux_pulse),
        .margin_clr  (margin_clr),
        .margin_flag (margin_flag)
    );

    assign clk_bit      = clk_ev.val;
    assign clk_bit_vld  = clk_ev.vld;
    assign data_bit     = dat_ev.val;
    assign data_bit_vld = dat_ev.vld;

endmodule

// File: rtl/sep_separator_chk.sv
module sep_separator_chk (
    input logic clk,
    input logic rst_n,
    input logic cell_start,
    input logic flux_pulse,
    input logic margin_clr,
    input logic clk_bit,
    input logic clk_bit_vld,
    input logic data_bit,
    input logic data_bit_vld,
    input logic margin_flag
);

    // R3
    clk_bit_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_bit_vld |-> !clk_bit);

    // R4
    data_bit_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_bit_vld |-> !data_bit);

    // R4
    data_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_bit_vld |=> !data_bit_vld);

    // R10
    margin_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_flag && !margin_clr) |=> margin_flag);

    // R10
    margin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_clr && !flux_pulse) |=> !margin_flag);

    // R8
    margin_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(margin_flag) |-> $past(flux_pulse));

endmodule

bind sep_window_separator sep_separator_chk u_sep_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cell_start   (cell_start),
    .flux_pulse   (flux_pulse),
    .margin_clr   (margin_clr),
    .clk_bit      (clk_bit),
    .clk_bit_vld  (clk_bit_vld),
    .data_bit     (data_bit),
    .data_bit_vld (data_bit_vld),
    .margin_flag  (margin_flag)
);

// File: tb/sep_window_separator_tb.sv
`timescale 1ns/1ps
module sep_window_separator_tb;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic cell_start;
    logic flux_pulse;
    logic margin_clr;
    logic clk_bit, clk_bit_vld, data_bit, data_bit_vld, margin_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    int clk_t[$];
    int clk_b[$];
    int dat_t[$];
    int dat_b[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sep_window_separator u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cell_start   (cell_start),
        .flux_pulse   (flux_pulse),
        .margin_clr   (margin_clr),
        .clk_bit      (clk_bit),
        .clk_bit_vld  (clk_bit_vld),
        .data_bit     (data_bit),
        .data_bit_vld (data_bit_vld),
        .margin_flag  (margin_flag)
    );

    // strobe log, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && clk_bit_vld) begin
            clk_t.push_back(cyc);
            clk_b.push_back(int'(clk_bit));
        end
        if (rst_n && data_bit_vld) begin
            dat_t.push_back(cyc);
            dat_b.push_back(int'(data_bit));
        end
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr_log();
        @(posedge clk);
        clk_t.delete(); clk_b.delete(); dat_t.delete(); dat_b.delete();
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cell_start = 1'b0;
            flux_pulse = 1'b0;
            margin_clr = 1'b0;
        end
    endtask

    task automatic drive_cell(input logic [15:0] pmask, input logic [15:0] cmask,
                              input int len, output int start);
        start = 0;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            cell_start = (t == 0);
            flux_pulse = pmask[t];
            margin_clr = cmask[t];
            if (t == 0) start = cyc + 1;
        end
    endtask

    task automatic check_cell(input string req, input int s, input int ec, input int ed);
        chk_eq(req, "clock strobe count", clk_t.size(), 1);
        chk_eq(req, "data strobe count", dat_t.size(), 1);
        if (clk_t.size() > 0) begin
            chk_eq(req, "clock strobe cycle", clk_t[0], s + W - 1);
            chk_eq(req, "clock bit", clk_b[0], ec);
        end
        if (dat_t.size() > 0) begin
            chk_eq(req, "data strobe cycle", dat_t[0], s + 2 * W - 1);
            chk_eq(req, "data bit", dat_b[0], ed);
        end
    endtask

    task automatic clear_margin();
        idle(1);
        @(negedge clk); margin_clr = 1'b1;
        @(negedge clk); margin_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cell_start = 1'b0; flux_pulse = 1'b0; margin_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R1", "outputs in reset",
               int'({clk_bit, clk_bit_vld, data_bit, data_bit_vld, margin_flag}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "outputs after reset",
               int'({clk_bit, clk_bit_vld, data_bit, data_bit_vld, margin_flag}), 0);
    endtask

    // R2 R3 R4 R9: single interior pulses, windows placed by tick
    task automatic t_basic(input logic [15:0] pmask, input int ec, input int ed, input string req);
        int s;
        clear_margin();
        clr_log();
        drive_cell(pmask, 16'h0, 2 * W, s);
        idle(3);
        check_cell(req, s, ec, ed);
        chk_eq("R9", "margin after interior pulses", int'(margin_flag), 0);
    endtask

    // R6: pulses with no cell running
    task automatic t_outside();
        int s;
        clear_margin();
        clr_log();
        repeat (5) begin
            @(negedge clk); cell_start = 1'b0; flux_pulse = 1'b1; margin_clr = 1'b0;
        end
        idle(2);
        chk_eq("R6", "strobes before any cell", clk_t.size() + dat_t.size(), 0);
        drive_cell(16'h0000, 16'h0, 2 * W, s);
        repeat (6) begin
            @(negedge clk); cell_start = 1'b0; flux_pulse = 1'b1; margin_clr = 1'b0;
        end
        idle(3);
        chk_eq("R6", "strobes around ended cell", clk_t.size() + dat_t.size(), 2);
        chk_eq("R6", "clock bit of empty cell", (clk_b.size() > 0) ? clk_b[0] : -1, 0);
        chk_eq("R6", "data bit of empty cell", (dat_b.size() > 0) ? dat_b[0] : -1, 0);
        chk_eq("R6", "margin after stray pulses", int'(margin_flag), 0);
    endtask

    // R8: each window edge tick flags margin, bit still delivered
    task automatic t_margin_edges();
        int s;
        int edges[4] = '{0, W - 1, W, 2 * W - 1};
        foreach (edges[i]) begin
            clear_margin();
            chk_eq("R10", "flag cleared", int'(margin_flag), 0);
            clr_log();
            drive_cell(16'(1) << edges[i], 16'h0, 2 * W, s);
            idle(3);
            chk_eq("R8", $sformatf("margin at tick %0d", edges[i]), int'(margin_flag), 1);
            check_cell("R8", s, (edges[i] < W) ? 1 : 0, (edges[i] < W) ? 0 : 1);
        end
    endtask

    // R10: sticky across clean cells, set wins over simultaneous clear
    task automatic t_sticky();
        int s;
        clear_margin();
        clr_log();
        drive_cell(16'h0080, 16'h0, 2 * W, s);
        drive_cell(16'h0810, 16'h0, 2 * W, s);
        idle(3);
        chk_eq("R10", "flag held over clean cell", int'(margin_flag), 1);
        clear_margin();
        chk_eq("R10", "flag after clear", int'(margin_flag), 0);
        clr_log();
        drive_cell(16'h0001, 16'h0001, 2 * W, s);
        idle(3);
        chk_eq("R10", "set wins over clear", int'(margin_flag), 1);
    endtask

    // R7: short cell cut by next boundary
    task automatic t_early();
        int s1, s2;
        clear_margin();
        clr_log();
        drive_cell(16'h0400, 16'h0, 12, s1);
        drive_cell(16'h0001, 16'h0, 2 * W, s2);
        idle(3);
        chk_eq("R7", "second cell start", s2, s1 + 12);
        chk_eq("R7", "clock strobes", clk_t.size(), 2);
        chk_eq("R7", "data strobes", dat_t.size(), 2);
        if (clk_t.size() == 2) begin
            chk_eq("R7", "first clock cycle", clk_t[0], s1 + W - 1);
            chk_eq("R7", "first clock bit", clk_b[0], 0);
            chk_eq("R7", "second clock cycle", clk_t[1], s2 + W - 1);
            chk_eq("R7", "second clock bit", clk_b[1], 1);
        end
        if (dat_t.size() == 2) begin
            chk_eq("R7", "cut data cycle", dat_t[0], s1 + 12);
            chk_eq("R7", "cut data bit", dat_b[0], 1);
            chk_eq("R7", "second data bit", dat_b[1], 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic(16'h0008, 1, 0, "R3");
        t_basic(16'h0800, 0, 1, "R4");
        t_basic(16'h0000, 0, 0, "R2");
        t_basic(16'h3034, 1, 1, "R5");
        t_basic(16'h2040, 1, 1, "R2");
        t_outside();
        t_margin_edges();
        t_sticky();
        t_early();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule